// File: doc/BRIEF.md
# Multi-Input PWM Activity Watchdog

This block watches several PWM input lines and reports any line that has stopped producing rising edges. Each line goes through a synchronizer into the system clock domain. Each line then feeds its own timer. The timer returns to zero whenever a rising edge arrives on that line and otherwise counts clock cycles up to a programmable limit. A line whose timer reaches the limit before its next rising edge gets a per-line fault flag. That flag stays set until software sends a clear strobe.

The per-line flags are combined in two stages. A per-line mask keeps a flag out of the summary, but the flag itself is still recorded and visible. A global mask blocks the summary altogether. When the summary is active, an active-low error output is pulled low. A line held steadily high or low has no rising edges, so it always times out. Software is expected to mask such a line individually. A limit of zero turns detection off for every line.

Top module: `pwm_watchdog_top`

## Requirements
- R1: During and right after reset, all fault flags are 0, the summary output is 0 and the error output is 1.
- R2: With the default two-stage synchronizer, let edge 1 be the first clock edge that samples a line's new high level. If no further rising edge arrives, the line's fault flag becomes 1 on edge limit+4 and is still 0 after edge limit+3. The timer is zeroed on edge 3, the edge after the rise is detected.
- R3: A line that rises once every P cycles, with P at least 2, sets its fault flag exactly when P is greater than the limit.
- R4: A falling transition on a line does not restart its timer.
- R5: Fault flags are sticky. They return to 0 only on the edge where the clear strobe is 1. The timer holds at the limit instead of wrapping, so a line still timed out sets its flag again on the following edge.
- R6: A limit value of 0 sets no fault flag on any line, whatever the input activity.
- R7: A line's mask bit (bit i belongs to line i) does not stop its fault flag being set. A masked flag is excluded from the summary.
- R8: The summary output is 1 exactly when the global mask is 0 and some flag is 1 with its mask bit 0. The error output is the inverse of the summary. Both follow the flags and masks within the same cycle.
- R9: Each line's timer is independent. Rising edges on other lines do not keep a silent line from timing out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_n_i | input | NUM_IN | Monitored PWM lines, asynchronous to clk |
| timeout_i | input | CNT_W | Timeout limit in clock cycles, 0 disables detection |
| in_mask_i | input | NUM_IN | Per-line mask, 1 keeps that line out of the summary |
| glob_mask_i | input | 1 | Global mask, 1 blocks the summary and the error output |
| clr_i | input | 1 | Clear strobe for all fault flags |
| fault_o | output | NUM_IN | Sticky per-line fault flags |
| any_fault_o | output | 1 | Summary of unmasked faults |
| err_n_o | output | 1 | Active-low error output |

## Verification
A rising edge on a line reaches the timer after three register stages: two synchronizer flops and one edge-detect flop. With no further edge, the flag follows limit+1 edges later. The clear strobe acts on the edge where it is sampled, and a still-expired line sets its flag again one edge after that. Mask and global-mask changes reach the summary and error outputs combinationally in the same cycle.

The bench drives every input just after a falling clock edge. It counts rising edges from that point and samples at the next falling edge after the edge where a result is due. The limit sweeps check both sides of each boundary: the last edge where a flag must still be 0, and the edge where it must first be 1.

// File: rtl/pwmwd_pkg.sv
package pwmwd_pkg;

  localparam int unsigned PWMWD_DEF_LINES  = 6;
  localparam int unsigned PWMWD_DEF_CNT_W  = 16;
  localparam int unsigned PWMWD_DEF_STAGES = 2;

  // Per-line events produced by one channel watchdog.
  typedef struct packed {
    logic rise;
    logic expired;
    logic fault;
  } pwmwd_lane_t;

endpackage

// File: rtl/pwmwd_sync.sv
module pwmwd_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwmwd_chan.sv
module pwmwd_chan
  import pwmwd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output pwmwd_lane_t      lane_o
);

  // Timer step: zero on a rise, count up to the limit, hold there.
  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim,
    input logic             rise
  );
    if (rise)                       return '0;
    else if (lim != '0 && cur < lim) return cur + 1'b1;
    else                             return cur;
  endfunction

  function automatic logic is_expired(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim
  );
    return (lim != '0) && (cur >= lim);
  endfunction

  logic             lvl_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic             rise_w;
  logic             expired_w;

  assign rise_w    = lvl_i & ~lvl_d_q;
  assign expired_w = is_expired(cnt_q, limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d_q <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      cnt_q   <= step_count(cnt_q, limit_i, rise_w);
      if (clr_i) fault_q <= 1'b0;
      else       fault_q <= fault_q | expired_w;
    end
  end

  assign lane_o.rise    = rise_w;
  assign lane_o.expired = expired_w;
  assign lane_o.fault   = fault_q;

endmodule

// File: rtl/pwmwd_summary.sv
module pwmwd_summary #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] fault_i,
  input  logic [N-1:0] mask_i,
  input  logic         glob_mask_i,
  output logic         any_o,
  output logic         err_n_o
);

  function automatic logic unmasked_any(
    input logic [N-1:0] f,
    input logic [N-1:0] m,
    input logic         g
  );
    return !g && ((f & ~m) != '0);
  endfunction

  assign any_o   = unmasked_any(fault_i, mask_i, glob_mask_i);
  assign err_n_o = ~any_o;

endmodule

// File: rtl/pwm_watchdog_top.sv
module pwm_watchdog_top
  import pwmwd_pkg::*;
#(
  parameter int unsigned NUM_IN      = PWMWD_DEF_LINES,
  parameter int unsigned CNT_W       = PWMWD_DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = PWMWD_DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pwm_n_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [NUM_IN-1:0] in_mask_i,
  input  logic              glob_mask_i,
  input  logic              clr_i,
  output logic [NUM_IN-1:0] fault_o,
  output logic              any_fault_o,
  output logic              err_n_o
);

  logic [NUM_IN-1:0] sync_lvl;
  logic [NUM_IN-1:0] rise_w;
  logic [NUM_IN-1:0] expired_w;
  logic [NUM_IN-1:0] fault_w;
  pwmwd_lane_t       lanes [NUM_IN];

  pwmwd_sync #(
    .W      (NUM_IN),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pwm_n_i),
    .q_o   (sync_lvl)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    pwmwd_chan #(
      .CNT_W (CNT_W)
    ) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (sync_lvl[i]),
      .limit_i (timeout_i),
      .clr_i   (clr_i),
      .lane_o  (lanes[i])
    );
    assign rise_w[i]    = lanes[i].rise;
    assign expired_w[i] = lanes[i].expired;
    assign fault_w[i]   = lanes[i].fault;
  end

  pwmwd_summary #(
    .N (NUM_IN)
  ) sum_i (
    .fault_i     (fault_w),
    .mask_i      (in_mask_i),
    .glob_mask_i (glob_mask_i),
    .any_o       (any_fault_o),
    .err_n_o     (err_n_o)
  );

  assign fault_o = fault_w;

endmodule

// File: rtl/pwm_watchdog_chk.sv
module pwm_watchdog_chk #(
  parameter int unsigned NUM_IN = 6,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  timeout_i,
  input logic [NUM_IN-1:0] in_mask_i,
  input logic              glob_mask_i,
  input logic              clr_i,
  input logic [NUM_IN-1:0] fault_o,
  input logic              any_fault_o,
  input logic              err_n_o,
  input logic [NUM_IN-1:0] rise_w,
  input logic [NUM_IN-1:0] expired_w
);

  // R2: a detected rise leaves that timer below any nonzero limit.
  a_r2_rise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((expired_w & $past(rise_w)) == '0));

  // R5: the clear strobe empties every flag on its edge.
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (fault_o == '0));

  // R5: without a clear, set flags stay set.
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

  // R6: a zero limit sets no new flag.
  a_r6_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i == '0 && fault_o == '0) |=> (fault_o == '0));

  // R7: the summary needs at least one unmasked flag.
  a_r7_mask_excludes: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault_o |-> ((fault_o & ~in_mask_i) != '0));

  // R8: the global mask blocks summary and error output.
  a_r8_global_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    glob_mask_i |-> (!any_fault_o && err_n_o));

endmodule

bind pwm_watchdog_top pwm_watchdog_chk #(
  .NUM_IN (NUM_IN),
  .CNT_W  (CNT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .timeout_i   (timeout_i),
  .in_mask_i   (in_mask_i),
  .glob_mask_i (glob_mask_i),
  .clr_i       (clr_i),
  .fault_o     (fault_o),
  .any_fault_o (any_fault_o),
  .err_n_o     (err_n_o),
  .rise_w      (rise_w),
  .expired_w   (expired_w)
);

// File: tb/pwm_watchdog_top_tb_top.sv
`timescale 1ns/1ps
module pwm_watchdog_top_tb_top;

  localparam int N = 6;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pwm = '0;
  logic [W-1:0] tmo = '0;
  logic [N-1:0] msk = '0;
  logic         gmsk = 1'b0;
  logic         clr = 1'b0;
  logic [N-1:0] fault;
  logic         any_f;
  logic         err_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwm_watchdog_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_n_i     (pwm),
    .timeout_i   (tmo),
    .in_mask_i   (msk),
    .glob_mask_i (gmsk),
    .clr_i       (clr),
    .fault_o     (fault),
    .any_fault_o (any_f),
    .err_n_o     (err_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    ticks(3);
    check(fault == '0, "R1 flags in reset", 32'(fault), 0);
    check(any_f == 1'b0 && err_n == 1'b1, "R1 summary in reset", {any_f, err_n}, 32'b01);
    rst_n = 1'b1;
    tick();
    check(fault == '0 && any_f == 1'b0 && err_n == 1'b1, "R1 after release",
          {fault, any_f, err_n}, 32'b01);

    // R2 and R4: exact timeout edge after a single rise, per line and limit
    for (int k = 0; k < N; k++) begin
      for (int t = 1; t <= 6; t++) begin
        tmo = W'(t);
        ticks(t + 4);
        pwm[k] = 1'b1;
        ticks(2);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        pwm[k] = 1'b0;  // falling edge must not restart the timer (R4)
        for (int j = 1; j <= t; j++) begin
          tick();
          check(fault[k] == 1'b0, "R2 flag still clear before limit", 32'(fault[k]), 0);
        end
        tick();
        check(fault[k] == 1'b1, "R2 R4 flag set at limit+4", 32'(fault[k]), 1);
      end
    end

    // R3: periodic rises on line 0, sweep period against limit
    for (int p = 2; p <= 8; p++) begin
      for (int t = 1; t <= 7; t++) begin
        bit seen;
        bit exp_f;
        seen  = 1'b0;
        exp_f = (p > t);
        tmo   = W'(t);
        for (int i = 0; i < 8 * p; i++) begin
          pwm[0] = (i % p == 0);
          clr    = (i == 3 * p);
          tick();
          if (i > 3 * p && fault[0]) seen = 1'b1;
        end
        clr    = 1'b0;
        pwm[0] = 1'b0;
        check(fault[0] == exp_f && seen == exp_f, "R3 period versus limit",
              {p[15:0], 7'd0, seen, 7'd0, fault[0]}, 32'(exp_f));
      end
    end

    // R9: one silent line among active ones
    for (int k = 0; k < N; k++) begin
      tmo = W'(10);
      for (int i = 0; i < 60; i++) begin
        for (int c = 0; c < N; c++) pwm[c] = (c != k) && (i % 4 == 0);
        clr = (i == 12);
        tick();
      end
      clr = 1'b0;
      pwm = '0;
      check(fault == N'(1 << k), "R9 only the silent line faults", 32'(fault), 32'(1 << k));
    end

    // R5: sticky flags, clear and re-set from a held timer
    tmo = W'(3);
    ticks(20);
    check(fault == '1, "R5 all silent lines faulted", 32'(fault), 32'h3f);
    clr = 1'b1;
    tick();
    clr = 1'b0;
    check(fault == '0, "R5 clear drops flags", 32'(fault), 0);
    tick();
    check(fault == '1, "R5 held timeout sets again", 32'(fault), 32'h3f);
    tmo = '0;
    ticks(20);
    check(fault == '1, "R5 flags stay without clear", 32'(fault), 32'h3f);

    // R6: zero limit disables detection
    pulse_clear();
    for (int i = 0; i < 40; i++) begin
      pwm = (i < 20) ? '0 : '1;
      tick();
    end
    pwm = '0;
    ticks(4);
    check(fault == '0 && any_f == 1'b0, "R6 zero limit sets nothing", {fault, any_f}, 0);

    // R7 and R8: exhaustive mask sweep with every flag set
    tmo = W'(4);
    ticks(10);
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 64; m++) begin
        bit exp_any;
        msk  = N'(m);
        gmsk = g[0];
        #1;
        exp_any = (g == 0) && ((~m & 63) != 0);
        check(fault == '1, "R7 masked flags still stored", 32'(fault), 32'h3f);
        check(any_f == exp_any && err_n == !exp_any, "R8 summary and error",
              {any_f, err_n}, {exp_any, !exp_any});
        @(negedge clk);
      end
    end

    // R8: no flags at all gives no summary
    tmo = '0;
    gmsk = 1'b0;
    msk = '0;
    pulse_clear();
    check(any_f == 1'b0 && err_n == 1'b1, "R8 no flags no error", {any_f, err_n}, 32'b01);

    done = 1'b1;
    finish_run();
  end

endmodule